// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps a time-of-day value as a 48-bit seconds count and a nanoseconds count that stays below one billion. Each cycle in which the `tick` input is high, the nanoseconds count grows by a programmed increment. The increment has an 8-bit whole-nanosecond part and a 24-bit fraction that feeds an accumulator. When the nanoseconds count reaches one second it wraps, and the seconds count advances by one.

Software uses a simple register port with a write enable, an address and 32-bit data. Through this port it loads the time and the increment, applies one-shot signed offsets, and reads the time back. Some writes are staged and only take effect on a later write: the upper seconds half is committed by the lower seconds write, and the fraction is committed by the whole-nanosecond increment write. As a result, a multi-word update is never seen half-applied. Reading the nanoseconds register captures the seconds value at that moment, so a later seconds read returns the value that matches it.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset, the nanoseconds count, the seconds count, all staging registers, both increments and the fraction accumulator are zero. Ticks then leave the time at zero, and every register reads 0.
- R2: On a cycle with `tick` high, the nanoseconds count grows by the whole increment, which is set by a write to address 3 with the value in bits 7:0. With `tick` low and no write, the time holds.
- R3: The fraction is 24 bits. A write to address 4 places fraction bits 23:8 in data bits 15:0 and fraction bits 7:0 in data bits 31:24. A 24-bit accumulator adds the fraction on each tick, and its carry adds one extra nanosecond to that tick.
- R4: A fraction written to address 4 has no effect on counting until the next write to address 3, which commits it together with the new whole increment.
- R5: A nanoseconds count that reaches 1,000,000,000 wraps by that amount and increments the 48-bit seconds count, which itself wraps modulo 2^48.
- R6: A write to address 2 (bits 15:0) only stages the upper seconds and leaves the running seconds unchanged. A write to address 1 loads all 48 seconds as {staged upper, data}. In that cycle the nanoseconds still tick, but any carry into the seconds is dropped.
- R7: A write to address 0 loads the nanoseconds count with data bits 29:0, and the seconds are unchanged in that cycle. A value of 1,000,000,000 or more is ignored, so that cycle counts as if no write had occurred.
- R8: A write to address 5 applies an offset once. Bit 31 is the sign (1 subtracts) and bits 29:0 are the magnitude. The offset is applied on top of that cycle's tick. A borrow below zero adds one billion and decrements the seconds; a carry past one billion subtracts it and increments the seconds. A magnitude of one billion or more is ignored.
- R9: `rdata` is combinational from `addr`. Address 0 gives the live nanoseconds. A cycle with `rd_en` high at address 0 captures the seconds. Address 1 returns captured bits 31:0, address 2 returns captured bits 47:32 zero-extended, and any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Advance the time by one increment this cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Read strobe; at address 0 captures the seconds |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |

## Verification
Directed sequences drive the corners. An increment with a half-nanosecond fraction separates the accumulator carry from the whole increment. A fraction written without its commit shows that staging holds the old rate. A seconds load with the low word all ones, followed by a nanoseconds value just below one second, exposes the carry from the low 32 seconds bits into the upper ones. Subtractive and additive offsets around small and large nanosecond values check borrow and carry. Out-of-range nanoseconds and offset writes show that invalid values change nothing. A long random phase then mixes ticks, all six write addresses and reads of every address against a bench model, so that same-cycle combinations of tick, wrap and offset are compared cycle by cycle.

// File: rtl/ptp_tod_counter.sv
`timescale 1ns/1ps
module ptp_tod_counter #(
  parameter int SEC_HI_W = 16,
  parameter int INC_W    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  localparam int SEC_W  = 32 + SEC_HI_W;
  localparam int FRAC_W = 24;
  localparam logic [31:0] NS_PER_SEC = 32'd1_000_000_000;
  localparam logic [2:0] A_NS = 3'd0, A_SECLO = 3'd1, A_SECHI = 3'd2,
                         A_INCNS = 3'd3, A_INCSUB = 3'd4, A_ADJ = 3'd5;

  logic [31:0]         ns;
  logic [SEC_W-1:0]    sec, snap_sec;
  logic [SEC_HI_W-1:0] sec_hi_stage;
  logic [INC_W-1:0]    inc_ns;
  logic [FRAC_W-1:0]   inc_frac, frac_stage, frac_acc;

  wire wr_ns    = wr_en && addr == A_NS;
  wire wr_seclo = wr_en && addr == A_SECLO;
  wire wr_sechi = wr_en && addr == A_SECHI;
  wire wr_incns = wr_en && addr == A_INCNS;
  wire wr_sub   = wr_en && addr == A_INCSUB;
  wire wr_adj   = wr_en && addr == A_ADJ;

  // tick step with fraction carry
  wire [FRAC_W:0] frac_sum = {1'b0, frac_acc} + {1'b0, inc_frac};
  wire [31:0] step = tick ? 32'(inc_ns) + 32'(frac_sum[FRAC_W]) : 32'd0;
  wire [31:0] t0   = ns + step;
  wire        c1   = t0 >= NS_PER_SEC;
  wire [31:0] t1   = c1 ? t0 - NS_PER_SEC : t0;

  // one-shot offset
  wire [31:0] adj_mag = {2'b00, wdata[29:0]};
  wire        adj_sub = wdata[31];
  wire        adj_go  = wr_adj && adj_mag < NS_PER_SEC;
  wire [31:0] s_add   = t1 + adj_mag;
  wire        c2      = adj_go && !adj_sub && s_add >= NS_PER_SEC;
  wire        brw     = adj_go && adj_sub && t1 < adj_mag;
  wire [31:0] t2      = !adj_go ? t1 :
                        adj_sub ? (brw ? t1 + NS_PER_SEC - adj_mag : t1 - adj_mag) :
                                  (c2 ? s_add - NS_PER_SEC : s_add);
  wire [SEC_W-1:0] sec_nxt = sec + SEC_W'(c1) + SEC_W'(c2) - SEC_W'(brw);

  wire ns_load = wr_ns && adj_mag < NS_PER_SEC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ns           <= '0;
      sec          <= '0;
      snap_sec     <= '0;
      sec_hi_stage <= '0;
      inc_ns       <= '0;
      inc_frac     <= '0;
      frac_stage   <= '0;
      frac_acc     <= '0;
    end else begin
      if (tick) frac_acc <= frac_sum[FRAC_W-1:0];
      ns <= ns_load ? adj_mag : t2;
      if (wr_seclo)     sec <= {sec_hi_stage, wdata};
      else if (!ns_load) sec <= sec_nxt;
      if (wr_sechi) sec_hi_stage <= wdata[SEC_HI_W-1:0];
      if (wr_sub)   frac_stage <= {wdata[15:0], wdata[31:24]};
      if (wr_incns) begin
        inc_ns   <= wdata[INC_W-1:0];
        inc_frac <= frac_stage;
      end
      if (rd_en && addr == A_NS) snap_sec <= sec;
    end
  end

  always_comb begin
    case (addr)
      A_NS:    rdata = ns;
      A_SECLO: rdata = snap_sec[31:0];
      A_SECHI: rdata = 32'(snap_sec[SEC_W-1:32]);
      default: rdata = '0;
    endcase
  end

  assert_ns_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ns < NS_PER_SEC);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> ($stable(ns) && $stable(sec)));
  assert_sechi_staged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sechi && !tick) |=> $stable(sec));
  assert_sub_staged_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sub |=> ($stable(inc_frac) && $stable(inc_ns)));
  assert_sec_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (sec == $past(sec) || sec == $past(sec) + SEC_W'(1)));
  assert_snap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_NS) |=> snap_sec == $past(sec));
endmodule

// File: tb/tb_ptp_tod_counter.sv
`timescale 1ns/1ps
module tb_ptp_tod_counter;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  int checks = 0, fails = 0;

  ptp_tod_counter dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata));

  always #2.5 clk = ~clk;

  localparam longint BIL = 1000000000;
  longint m_ns = 0;
  logic [47:0] m_sec = 0, m_snap = 0;
  logic [15:0] m_hi = 0;
  logic [7:0]  m_inc = 0;
  logic [23:0] m_frac = 0, m_sub = 0, m_acc = 0;

  function automatic logic [31:0] exp_read(logic [2:0] a);
    case (a)
      3'd0: return 32'(m_ns);
      3'd1: return m_snap[31:0];
      3'd2: return {16'd0, m_snap[47:32]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_step(bit w, logic [2:0] a, logic [31:0] d, bit t, bit r);
    longint tot, step;
    logic [24:0] fs;
    logic [47:0] s;
    step = 0;
    fs = {1'b0, m_acc} + {1'b0, m_frac};
    if (t) step = longint'(m_inc) + longint'(fs[24]);
    if (r && a == 3'd0) m_snap = m_sec;
    s = m_sec;
    if (w && a == 3'd0 && longint'(d[29:0]) < BIL) begin
      m_ns = longint'(d[29:0]);
    end else begin
      tot = m_ns + step;
      if (w && a == 3'd5 && longint'(d[29:0]) < BIL)
        tot = d[31] ? tot - longint'(d[29:0]) : tot + longint'(d[29:0]);
      while (tot >= BIL) begin tot -= BIL; s = s + 48'd1; end
      while (tot < 0) begin tot += BIL; s = s - 48'd1; end
      m_ns = tot;
      m_sec = s;
    end
    if (w && a == 3'd1) m_sec = {m_hi, d};
    if (t) m_acc = fs[23:0];
    if (w && a == 3'd2) m_hi = d[15:0];
    if (w && a == 3'd4) m_sub = {d[15:0], d[31:24]};
    if (w && a == 3'd3) begin m_inc = d[7:0]; m_frac = m_sub; end
  endtask

  task automatic cyc(bit w, logic [2:0] a, logic [31:0] d, bit t, bit r, string tag);
    logic [31:0] e;
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; tick = t; rd_en = r;
    #1;
    e = exp_read(a);
    checks++;
    if (rdata !== e) begin
      fails++;
      $display("FAIL %s addr=%0d actual=%0d expected=%0d", tag, a, rdata, e);
    end
    model_step(w, a, d, t, r);
    @(posedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d, bit t, string tag);
    cyc(1, a, d, t, 0, tag);
  endtask

  task automatic ticks(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 3'd0, 0, 1, 0, tag);
  endtask

  task automatic read_all(string tag);
    cyc(0, 3'd0, 0, 0, 1, tag);
    cyc(0, 3'd1, 0, 0, 0, tag);
    cyc(0, 3'd2, 0, 0, 0, tag);
    cyc(0, 3'd6, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [2:0] a;
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset state, zero increment holds time
    read_all("R1");
    ticks(4, "R1");
    read_all("R1");
    // R2: whole increment
    wr(3'd3, 32'd8, 0, "R2");
    ticks(5, "R2");
    cyc(0, 3'd0, 0, 0, 0, "R2");
    cyc(0, 3'd0, 0, 0, 0, "R2");
    // R4: staged fraction not yet used
    wr(3'd4, 32'h0000_8000, 1, "R4");
    ticks(3, "R4");
    // R3: half-ns fraction committed
    wr(3'd3, 32'd5, 1, "R3");
    ticks(6, "R3");
    wr(3'd4, 32'h4000_0040, 0, "R3");
    wr(3'd3, 32'd7, 0, "R3");
    ticks(9, "R3");
    // R6: upper seconds staged, lower commits
    wr(3'd2, 32'h0000_1234, 0, "R6");
    read_all("R6");
    wr(3'd1, 32'hFFFF_FFFF, 1, "R6");
    read_all("R6");
    // R7 and R5: near-wrap load, carry into upper seconds
    wr(3'd0, 32'd999_999_990, 0, "R7");
    cyc(0, 3'd0, 0, 0, 0, "R7");
    ticks(3, "R5");
    read_all("R5");
    wr(3'd0, 32'd1_000_000_000, 0, "R7");
    cyc(0, 3'd0, 0, 0, 0, "R7");
    // R8: offset borrow and carry
    wr(3'd5, 32'h8000_0000 | 32'd500_000_000, 1, "R8");
    read_all("R8");
    wr(3'd5, 32'd999_999_999, 0, "R8");
    read_all("R8");
    wr(3'd5, 32'h3FFF_FFFF, 1, "R8");
    read_all("R8");
    // R9: capture seconds across wrap
    wr(3'd3, 32'd255, 0, "R9");
    wr(3'd0, 32'd999_999_800, 0, "R9");
    cyc(0, 3'd0, 0, 1, 1, "R9");
    cyc(0, 3'd1, 0, 1, 0, "R9");
    read_all("R9");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      a = 3'($urandom % 6);
      d = $urandom;
      if (a == 3'd0) begin
        case ($urandom % 4)
          0: d = 32'd1_000_000_000 + ($urandom % 4096);
          1: d = 32'd999_999_000 + ($urandom % 1000);
          default: d = $urandom % 32'd1_000_000_000;
        endcase
      end else if (a == 3'd5 && ($urandom % 4) != 0) begin
        d = {d[31], 1'b0, 30'($urandom % 32'd1_000_000_000)};
      end
      cyc(($urandom % 6) == 0, a, d, ($urandom % 4) != 0, ($urandom % 3) == 0,
          a == 3'd5 ? "R8" : a == 3'd0 ? "R5" : "R9");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule